// File: doc/BRIEF.md
# Burst-Addressed Synchronous Dual-Port RAM

This block is a two-port word memory. Both ports share one clock, and either port can read or write any word in the same cycle as the other. Each port captures its enable, write strobe, byte-lane mask, address, counter controls and write data on the rising clock edge. The memory array acts on that captured request at the next edge.

Each port has its own burst pointer, which also serves as its registered access address. The pointer can be cleared to zero, loaded from the external address, or stepped to the next word, wrapping at the end of the array. When no counter control is given, the external address passes straight into the pointer. A single mode pin selects flow-through reads or pipelined reads. Pipelined reads go through one extra output register.

Read results leave each port as a valid flag plus data. The port has no ready input and cannot apply back-pressure, so a consumer must take every beat in the cycle its valid flag is high. Whenever valid is low, the data bus reads zero.

Top module: `dpram_burst`

## Requirements
- R1: While reset is asserted and after reset is released with no read issued, both ports drive `rvalid`=0 and `rdata`=0.
- R2: The two ports can each perform a read or write in the same cycle, each at its own address, and neither affects the other's result.
- R3: With `pipe_sel`=0 (flow-through), a read presented before rising edge k has `rvalid`=1 and the word on `rdata` after edge k+1, for exactly one cycle.
- R4: With `pipe_sel`=1 (pipelined), that read result appears one cycle later, after edge k+2, for exactly one cycle.
- R5: A port whose `ld` input is 1 accesses the word at its external `addr` in that request. The pointer now holds that address.
- R6: A port whose `inc` input is 1 (with `ld` and `clr` at 0) accesses the word one above its previous access address.
- R7: Stepping from address DEPTH-1 goes to address 0.
- R8: Counter control priority is `clr` (address 0), then `ld`, then `inc`. With none of the three set, the request uses the external `addr`.
- R9: A request with `en`=0 neither reads nor writes: no valid beat results, `rdata` stays 0, and the addressed word keeps its contents.
- R10: When both ports write the same word in the same cycle, the A port's data is stored. A read in the same cycle as a write to the same word by the other port returns the old word.
- R11: Write lane l (bit l of `be`) covers data bits l*LANE_W+LANE_W-1 down to l*LANE_W. Lanes whose bit is 0 keep their old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| rst_n | input | 1 | Asynchronous active-low reset |
| pipe_sel | input | 1 | 1 = pipelined reads, 0 = flow-through reads |
| a_en | input | 1 | Port A request enable |
| a_we | input | 1 | Port A write (1) or read (0) |
| a_be | input | LANES | Port A byte-lane write mask |
| a_addr | input | ADDR_W | Port A external address |
| a_ld | input | 1 | Port A load pointer from a_addr |
| a_inc | input | 1 | Port A step pointer |
| a_clr | input | 1 | Port A clear pointer |
| a_wdata | input | DATA_W | Port A write data |
| a_rvalid | output | 1 | Port A read beat valid |
| a_rdata | output | DATA_W | Port A read data, zero when not valid |
| b_en | input | 1 | Port B request enable |
| b_we | input | 1 | Port B write (1) or read (0) |
| b_be | input | LANES | Port B byte-lane write mask |
| b_addr | input | ADDR_W | Port B external address |
| b_ld | input | 1 | Port B load pointer from b_addr |
| b_inc | input | 1 | Port B step pointer |
| b_clr | input | 1 | Port B clear pointer |
| b_wdata | input | DATA_W | Port B write data |
| b_rvalid | output | 1 | Port B read beat valid |
| b_rdata | output | DATA_W | Port B read data, zero when not valid |

## Verification
The tests start with plain externally addressed traffic on both ports at once: A fills one region while B fills another, then each port reads the region the other wrote. This separates cross-port independence from simple per-port echo.

Burst runs then exercise the counter controls:
- a load followed by steps, which separates loading from stepping;
- a step across the top address, which separates wrap from overflow;
- loads and steps given together with a clear, which expose the priority order.

Further patterns check the remaining write rules:
- disabled writes followed by reads of the same words;
- same-word writes from both ports;
- a read paired with a write to the same word;
- partial lane masks.

These show whether ignoring, winner selection, old-data returns and lane merging behave as required. The traffic is run in both read modes, with a disabled cycle in pipelined mode, so the single-cycle latency difference is measured beat by beat.

// File: rtl/dpram_pkg.sv
package dpram_pkg;

  typedef enum logic [1:0] {
    CTR_EXT  = 2'd0,
    CTR_STEP = 2'd1,
    CTR_LOAD = 2'd2,
    CTR_CLR  = 2'd3
  } ctr_op_e;

  // Clear outranks load, load outranks step.
  function automatic ctr_op_e ctr_pick(input logic clr, input logic ld, input logic inc);
    if (clr)      return CTR_CLR;
    else if (ld)  return CTR_LOAD;
    else if (inc) return CTR_STEP;
    else          return CTR_EXT;
  endfunction

endpackage

// File: rtl/dpram_front.sv
module dpram_front
  import dpram_pkg::*;
#(
  parameter int DATA_W = 36,
  parameter int LANES  = 4,
  parameter int DEPTH  = 1024,
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              we,
  input  logic [LANES-1:0]  be,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ld,
  input  logic              inc,
  input  logic              clr,
  input  logic [DATA_W-1:0] wdata,
  output logic              acc_en,
  output logic              acc_we,
  output logic [LANES-1:0]  acc_be,
  output logic [DATA_W-1:0] acc_wdata,
  output logic [ADDR_W-1:0] acc_addr
);

  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

  ctr_op_e           op;
  logic [ADDR_W-1:0] nxt;

  assign op = ctr_pick(clr, ld, inc);

  always_comb begin
    case (op)
      CTR_CLR:  nxt = '0;
      CTR_LOAD: nxt = addr;
      CTR_STEP: nxt = (acc_addr == LAST) ? '0 : acc_addr + ADDR_W'(1);
      default:  nxt = addr;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_en    <= 1'b0;
      acc_we    <= 1'b0;
      acc_be    <= '0;
      acc_wdata <= '0;
      acc_addr  <= '0;
    end else begin
      acc_en    <= en;
      acc_we    <= we;
      acc_be    <= be;
      acc_wdata <= wdata;
      acc_addr  <= nxt;
    end
  end

endmodule

// File: rtl/dpram_array.sv
module dpram_array #(
  parameter int DATA_W = 36,
  parameter int LANE_W = 9,
  parameter int LANES  = 4,
  parameter int DEPTH  = 1024,
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              a_en,
  input  logic              a_we,
  input  logic [LANES-1:0]  a_be,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [DATA_W-1:0] a_wdata,
  input  logic              b_en,
  input  logic              b_we,
  input  logic [LANES-1:0]  b_be,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [DATA_W-1:0] b_wdata,
  output logic [DATA_W-1:0] a_q,
  output logic [DATA_W-1:0] b_q
);

  logic [DATA_W-1:0] mem [DEPTH];

  // Reads sample before this edge's writes land, so a colliding read sees old data.
  // Port A's lane writes are issued last and therefore win on the same word.
  always_ff @(posedge clk) begin
    if (a_en && !a_we) a_q <= mem[a_addr];
    if (b_en && !b_we) b_q <= mem[b_addr];
    for (int l = 0; l < LANES; l++) begin
      if (b_en && b_we && b_be[l])
        mem[b_addr][l*LANE_W +: LANE_W] <= b_wdata[l*LANE_W +: LANE_W];
      if (a_en && a_we && a_be[l])
        mem[a_addr][l*LANE_W +: LANE_W] <= a_wdata[l*LANE_W +: LANE_W];
    end
  end

endmodule

// File: rtl/dpram_out.sv
module dpram_out #(
  parameter int DATA_W = 36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pipe_sel,
  input  logic              rd_fire,
  input  logic [DATA_W-1:0] q,
  output logic              rvalid,
  output logic [DATA_W-1:0] rdata
);

  logic              v1;
  logic              v2;
  logic [DATA_W-1:0] d2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1 <= 1'b0;
      v2 <= 1'b0;
      d2 <= '0;
    end else begin
      v1 <= rd_fire;
      v2 <= v1;
      d2 <= q;
    end
  end

  always_comb begin
    if (pipe_sel) begin
      rvalid = v2;
      rdata  = v2 ? d2 : '0;
    end else begin
      rvalid = v1;
      rdata  = v1 ? q : '0;
    end
  end

endmodule

// File: rtl/dpram_burst.sv
module dpram_burst #(
  parameter  int DATA_W = 36,
  parameter  int LANE_W = 9,
  parameter  int DEPTH  = 1024,
  localparam int LANES  = DATA_W / LANE_W,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pipe_sel,
  input  logic              a_en,
  input  logic              a_we,
  input  logic [LANES-1:0]  a_be,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic              a_ld,
  input  logic              a_inc,
  input  logic              a_clr,
  input  logic [DATA_W-1:0] a_wdata,
  output logic              a_rvalid,
  output logic [DATA_W-1:0] a_rdata,
  input  logic              b_en,
  input  logic              b_we,
  input  logic [LANES-1:0]  b_be,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic              b_ld,
  input  logic              b_inc,
  input  logic              b_clr,
  input  logic [DATA_W-1:0] b_wdata,
  output logic              b_rvalid,
  output logic [DATA_W-1:0] b_rdata
);

  localparam int NP = 2;

  logic [NP-1:0]     en_i, we_i, ld_i, inc_i, clr_i;
  logic [NP-1:0]     acc_en, acc_we, rvalid_o;
  logic [LANES-1:0]  be_i [NP];
  logic [LANES-1:0]  acc_be [NP];
  logic [DATA_W-1:0] wd_i [NP];
  logic [DATA_W-1:0] acc_wd [NP];
  logic [DATA_W-1:0] q_o [NP];
  logic [DATA_W-1:0] rdata_o [NP];
  logic [ADDR_W-1:0] addr_i [NP];
  logic [ADDR_W-1:0] acc_addr [NP];

  assign en_i  = {b_en, a_en};
  assign we_i  = {b_we, a_we};
  assign ld_i  = {b_ld, a_ld};
  assign inc_i = {b_inc, a_inc};
  assign clr_i = {b_clr, a_clr};
  assign be_i[0]   = a_be;
  assign be_i[1]   = b_be;
  assign wd_i[0]   = a_wdata;
  assign wd_i[1]   = b_wdata;
  assign addr_i[0] = a_addr;
  assign addr_i[1] = b_addr;

  for (genvar p = 0; p < NP; p++) begin : g_port
    dpram_front #(
      .DATA_W(DATA_W), .LANES(LANES), .DEPTH(DEPTH), .ADDR_W(ADDR_W)
    ) i_front (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (en_i[p]),
      .we       (we_i[p]),
      .be       (be_i[p]),
      .addr     (addr_i[p]),
      .ld       (ld_i[p]),
      .inc      (inc_i[p]),
      .clr      (clr_i[p]),
      .wdata    (wd_i[p]),
      .acc_en   (acc_en[p]),
      .acc_we   (acc_we[p]),
      .acc_be   (acc_be[p]),
      .acc_wdata(acc_wd[p]),
      .acc_addr (acc_addr[p])
    );

    dpram_out #(.DATA_W(DATA_W)) i_out (
      .clk     (clk),
      .rst_n   (rst_n),
      .pipe_sel(pipe_sel),
      .rd_fire (acc_en[p] & ~acc_we[p]),
      .q       (q_o[p]),
      .rvalid  (rvalid_o[p]),
      .rdata   (rdata_o[p])
    );
  end

  dpram_array #(
    .DATA_W(DATA_W), .LANE_W(LANE_W), .LANES(LANES), .DEPTH(DEPTH), .ADDR_W(ADDR_W)
  ) i_array (
    .clk    (clk),
    .a_en   (acc_en[0]),
    .a_we   (acc_we[0]),
    .a_be   (acc_be[0]),
    .a_addr (acc_addr[0]),
    .a_wdata(acc_wd[0]),
    .b_en   (acc_en[1]),
    .b_we   (acc_we[1]),
    .b_be   (acc_be[1]),
    .b_addr (acc_addr[1]),
    .b_wdata(acc_wd[1]),
    .a_q    (q_o[0]),
    .b_q    (q_o[1])
  );

  assign a_rvalid = rvalid_o[0];
  assign b_rvalid = rvalid_o[1];
  assign a_rdata  = rdata_o[0];
  assign b_rdata  = rdata_o[1];

endmodule

// File: rtl/dpram_burst_chk.sv
module dpram_burst_chk #(
  parameter int DEPTH  = 1024,
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pipe_sel,
  input logic              a_en,
  input logic              a_we,
  input logic              b_en,
  input logic              b_we,
  input logic              a_rvalid,
  input logic              b_rvalid,
  input logic              a_ld,
  input logic              a_inc,
  input logic              a_clr,
  input logic [ADDR_W-1:0] a_addr,
  input logic [ADDR_W-1:0] a_ptr
);

  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

  AST_FLOW_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe_sel && a_rvalid) |-> $past(a_en && !a_we, 2)); // R3

  AST_PIPE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe_sel && b_rvalid) |-> $past(b_en && !b_we, 3)); // R4

  AST_SLEEP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe_sel && $past(rst_n) && !$past(b_en, 2)) |-> !b_rvalid); // R9

  AST_LOAD_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(a_ld && !a_clr)) |-> (a_ptr == $past(a_addr))); // R5

  AST_STEP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(a_inc && !a_ld && !a_clr)) |->
      (a_ptr == (($past(a_ptr) == LAST) ? '0 : ADDR_W'($past(a_ptr) + 1'b1)))); // R7

  AST_CLEAR_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(a_clr)) |-> (a_ptr == '0)); // R8

endmodule

bind dpram_burst dpram_burst_chk #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) i_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .pipe_sel(pipe_sel),
  .a_en    (a_en),
  .a_we    (a_we),
  .b_en    (b_en),
  .b_we    (b_we),
  .a_rvalid(a_rvalid),
  .b_rvalid(b_rvalid),
  .a_ld    (a_ld),
  .a_inc   (a_inc),
  .a_clr   (a_clr),
  .a_addr  (a_addr),
  .a_ptr   (acc_addr[0])
);

// File: tb/test_dpram_burst.sv
`timescale 1ns/1ps
module test_dpram_burst;

  localparam int DW = 36;
  localparam int LW = 9;
  localparam int NL = 4;
  localparam int DEPTH = 1024;
  localparam int AW = 10;

  typedef struct packed {
    logic          en;
    logic          we;
    logic [NL-1:0] be;
    logic [AW-1:0] addr;
    logic          ld;
    logic          inc;
    logic          clr;
    logic [DW-1:0] wd;
  } op_t;

  typedef struct {
    int          due;
    logic [DW-1:0] data;
    string       tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pipe_sel = 1'b0;
  logic a_en = 0, a_we = 0, a_ld = 0, a_inc = 0, a_clr = 0;
  logic b_en = 0, b_we = 0, b_ld = 0, b_inc = 0, b_clr = 0;
  logic [NL-1:0] a_be = '0, b_be = '0;
  logic [AW-1:0] a_addr = '0, b_addr = '0;
  logic [DW-1:0] a_wdata = '0, b_wdata = '0;
  logic a_rvalid, b_rvalid;
  logic [DW-1:0] a_rdata, b_rdata;

  always #10 clk = ~clk;

  dpram_burst i_dpram_burst (
    .clk(clk), .rst_n(rst_n), .pipe_sel(pipe_sel),
    .a_en(a_en), .a_we(a_we), .a_be(a_be), .a_addr(a_addr), .a_ld(a_ld),
    .a_inc(a_inc), .a_clr(a_clr), .a_wdata(a_wdata),
    .a_rvalid(a_rvalid), .a_rdata(a_rdata),
    .b_en(b_en), .b_we(b_we), .b_be(b_be), .b_addr(b_addr), .b_ld(b_ld),
    .b_inc(b_inc), .b_clr(b_clr), .b_wdata(b_wdata),
    .b_rvalid(b_rvalid), .b_rdata(b_rdata)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit mon_on = 0;
  bit done = 0;
  logic [DW-1:0] ref_mem [DEPTH];
  int rptr [2];
  exp_t sb [2][$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic op_t mk(input bit en, input bit we, input logic [NL-1:0] be, input int addr,
                             input bit ld, input bit inc, input bit clr, input logic [DW-1:0] wd);
    op_t o;
    o.en = en; o.we = we; o.be = be; o.addr = AW'(addr);
    o.ld = ld; o.inc = inc; o.clr = clr; o.wd = wd;
    return o;
  endfunction

  function automatic op_t nop();
    return mk(0, 0, 4'h0, 0, 0, 0, 0, '0);
  endfunction

  function automatic op_t rd(input int addr);
    return mk(1, 0, 4'h0, addr, 0, 0, 0, '0);
  endfunction

  function automatic op_t wr(input int addr, input logic [DW-1:0] wd);
    return mk(1, 1, 4'hF, addr, 0, 0, 0, wd);
  endfunction

  // Driver: presents one request per port and pushes the expected read beats.
  task automatic drive(input op_t oa, input op_t ob, input string tag);
    op_t o [2];
    exp_t e;
    @(negedge clk);
    a_en = oa.en; a_we = oa.we; a_be = oa.be; a_addr = oa.addr;
    a_ld = oa.ld; a_inc = oa.inc; a_clr = oa.clr; a_wdata = oa.wd;
    b_en = ob.en; b_we = ob.we; b_be = ob.be; b_addr = ob.addr;
    b_ld = ob.ld; b_inc = ob.inc; b_clr = ob.clr; b_wdata = ob.wd;
    o[0] = oa; o[1] = ob;
    for (int p = 0; p < 2; p++) begin
      if (o[p].clr)      rptr[p] = 0;
      else if (o[p].ld)  rptr[p] = int'(o[p].addr);
      else if (o[p].inc) rptr[p] = (rptr[p] == DEPTH - 1) ? 0 : rptr[p] + 1;
      else               rptr[p] = int'(o[p].addr);
      if (o[p].en && !o[p].we) begin
        e.due = cyc + 2 + (pipe_sel ? 1 : 0);
        e.data = ref_mem[rptr[p]];
        e.tag = tag;
        sb[p].push_back(e);
      end
    end
    for (int p = 1; p >= 0; p--) begin
      if (o[p].en && o[p].we) begin
        for (int l = 0; l < NL; l++) begin
          if (o[p].be[l]) ref_mem[rptr[p]][l*LW +: LW] = o[p].wd[l*LW +: LW];
        end
      end
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(nop(), nop(), "R9 idle");
  endtask

  // Monitor: pops a beat when due, otherwise requires a quiet port.
  initial begin
    wait (mon_on);
    forever begin
      @(negedge clk);
      for (int p = 0; p < 2; p++) begin
        logic v;
        logic [DW-1:0] d;
        v = (p == 0) ? a_rvalid : b_rvalid;
        d = (p == 0) ? a_rdata : b_rdata;
        if (sb[p].size() > 0 && sb[p][0].due == cyc) begin
          chk(v === 1'b1 && d === sb[p][0].data, sb[p][0].tag, d, sb[p][0].data);
          void'(sb[p].pop_front());
        end else begin
          chk(v === 1'b0 && d === '0, (p == 0) ? "R9 quiet A" : "R9 quiet B", d, '0);
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rptr[0] = 0; rptr[1] = 0;
    repeat (3) @(negedge clk);
    // R1: quiet outputs during reset
    chk(a_rvalid === 1'b0 && a_rdata === '0, "R1 reset A", a_rdata, '0);
    chk(b_rvalid === 1'b0 && b_rdata === '0, "R1 reset B", b_rdata, '0);
    rst_n = 1'b1;
    mon_on = 1;
    idle(2);

    // R2: both ports write different regions in the same cycles
    for (int i = 0; i < 16; i++)
      drive(wr(i, 36'(i * 36'h111 + 36'h100000)), wr(16 + i, 36'(i * 36'h2345 + 36'h800000)), "R2 fill");
    // R2 / R3: each port reads the other port's region in flow-through mode
    for (int i = 0; i < 16; i++)
      drive(rd(16 + i), rd(i), "R2 R3 cross read");
    idle(2);

    // R5 load, R6 step
    drive(mk(1, 0, 4'h0, 4, 1, 0, 0, '0), nop(), "R5 load read");
    for (int i = 0; i < 3; i++)
      drive(mk(1, 0, 4'h0, 900, 0, 1, 0, '0), nop(), "R6 step read");
    // R6: write burst via stepping, then read back
    drive(mk(1, 1, 4'hF, 100, 1, 0, 0, 36'hA0A0A0A01), nop(), "R6 burst write");
    drive(mk(1, 1, 4'hF, 0, 0, 1, 0, 36'hA0A0A0A02), nop(), "R6 burst write");
    drive(mk(1, 1, 4'hF, 0, 0, 1, 0, 36'hA0A0A0A03), nop(), "R6 burst write");
    drive(rd(100), rd(101), "R6 burst readback");
    drive(rd(102), nop(), "R6 burst readback");

    // R7: wrap from the top address to 0
    drive(nop(), wr(1022, 36'h3FE3FE3FE), "R7 setup");
    drive(nop(), wr(1023, 36'h3FF3FF3FF), "R7 setup");
    drive(nop(), mk(1, 0, 4'h0, 1022, 1, 0, 0, '0), "R7 load top");
    drive(nop(), mk(1, 0, 4'h0, 5, 0, 1, 0, '0), "R7 step top");
    drive(nop(), mk(1, 0, 4'h0, 5, 0, 1, 0, '0), "R7 wrap to zero");

    // R8: clear beats load and step; load beats step
    drive(mk(1, 0, 4'h0, 9, 1, 1, 1, '0), nop(), "R8 clear priority");
    drive(mk(1, 0, 4'h0, 12, 1, 1, 0, '0), nop(), "R8 load over step");
    drive(rd(13), nop(), "R8 external address");
    idle(1);

    // R9: disabled write leaves the word alone, disabled read gives no beat
    drive(mk(0, 1, 4'hF, 3, 0, 0, 0, 36'hDEADBEEF0), mk(0, 0, 4'h0, 3, 0, 0, 0, '0), "R9 disabled");
    drive(rd(3), rd(3), "R9 word kept");

    // R10: same-word double write, A wins
    drive(wr(40, 36'h111111111), wr(40, 36'h222222222), "R10 collide");
    drive(rd(40), rd(40), "R10 left wins");
    // R10: read during other port's write returns old data, then new
    drive(wr(5, 36'h555555555), rd(5), "R10 old data");
    drive(nop(), rd(5), "R10 new data");

    // R11: partial lane write
    drive(mk(1, 1, 4'b0101, 6, 0, 0, 0, 36'hFFFFFFFFF), nop(), "R11 lanes write");
    drive(rd(6), nop(), "R11 lanes merged");
    drive(nop(), mk(1, 1, 4'b1000, 6, 0, 0, 0, 36'h0), "R11 top lane");
    drive(nop(), rd(6), "R11 top lane read");
    idle(4);

    // R4: pipelined mode, one extra cycle
    pipe_sel = 1'b1;
    idle(2);
    drive(rd(0), rd(31), "R4 pipe read");
    drive(rd(1), rd(30), "R4 pipe read");
    drive(mk(1, 0, 4'h0, 20, 1, 0, 0, '0), nop(), "R4 R5 pipe load");
    drive(mk(1, 0, 4'h0, 0, 0, 1, 0, '0), nop(), "R4 R6 pipe step");
    drive(nop(), nop(), "R9 pipe sleep");
    drive(rd(2), wr(7, 36'h777000777), "R4 R9 wake read");
    drive(nop(), rd(7), "R4 pipe write readback");
    drive(wr(8, 36'h888888888), rd(8), "R4 R10 pipe old data");
    idle(6);

    chk(sb[0].size() == 0 && sb[1].size() == 0, "R3 R4 all beats seen",
        DW'(sb[0].size() + sb[1].size()), '0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule